// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block is the digital counting section of a PLL frequency synthesizer. It has two independent dividers, and each produces a one-cycle pulse for a phase/frequency detector. The reference path divides the master clock by a value R. This gives the comparison rate, for example 1 MHz from a 12, 13 or 16 MHz master clock. The feedback path divides the synthesized clock by 32·N + A. It does this with a dual-modulus 32/33 prescaler, a programmable cycle counter N and a swallow counter A. The swallow counter selects divide-by-33 for the first A prescaler cycles of each output period, and divide-by-32 for the remaining N − A cycles.

A set of divider values is loaded with a one-cycle strobe in the clock domain that the values belong to. Each accepted value is held as pending until the current output period ends. At the next period boundary it replaces the active value, so a period is never cut short. If a feedback load would make the swallow count larger than the cycle count, or would make the cycle count zero, it is discarded. If a reference value lies outside the legal range, it is discarded too. The divided clock is treated as an ordinary digital clock.

Top module: `pulse_swallow_div`

## Requirements
- R1: While rst_ni is low, both pulse outputs are 0, and the active settings are the reset parameters N_RST, A_RST and R_RST (defaults 75, 2 and 16).
- R2: With active values N and A, fb_pulse_o is high for exactly one vco_clk_i cycle in every 32·N + A cycles. The first pulse appears after the (32·N + A)-th rising edge following reset release.
- R3: Inside each feedback period, the prescaler counts 33 cycles for each of the first A prescaler cycles and 32 cycles for each of the rest. A = 0 therefore gives a ratio of 32·N.
- R4: A = N is legal, and it gives a ratio of 33·N.
- R5: A feedback load with A > N is discarded, and the previous settings stay in effect.
- R6: A feedback load with N = 0 is discarded, and the previous settings stay in effect.
- R7: An accepted feedback load leaves the current period at its old length, and the new ratio applies from the next period on. If several loads come within one period, the last one wins.
- R8: With active value R, ref_pulse_o is high for exactly one ref_clk_i cycle in every R cycles.
- R9: A reference load with R below R_MIN (5) or above R_MAX (20) is discarded.
- R10: An accepted reference load takes effect at the next reference-period boundary.
- R11: Neither pulse output is ever high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk_i | input | 1 | Clock being divided (feedback path) |
| ref_clk_i | input | 1 | Master clock (reference path) |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| fb_load_i | input | 1 | Load strobe for fb_n_i/fb_a_i, sampled on vco_clk_i |
| fb_n_i | input | 7 | Programmable cycle count N |
| fb_a_i | input | 5 | Swallow count A (0..31) |
| ref_load_i | input | 1 | Load strobe for ref_div_i, sampled on ref_clk_i |
| ref_div_i | input | 5 | Reference divide value R |
| fb_pulse_o | output | 1 | One-cycle pulse at the end of each feedback period |
| ref_pulse_o | output | 1 | One-cycle pulse at the end of each reference period |

## Verification
Each pulse is registered, so it appears in the cycle that follows the last clock edge of its period. That is exactly L rising edges after the period began, where L is 32·N + A or R. The bench keeps a separate edge-count model for each clock domain and updates it on each rising edge. It compares both outputs at every falling edge, so every cycle is checked, including the cycles where no pulse is expected. A load takes one edge to reach the pending register and changes the period length only after the next pulse, and the model applies the same order at the boundary edge. A load made before the boundary therefore shows up as a changed period length only one period later.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  localparam int unsigned PRE_W = 5;   // prescaler low modulus = 2**PRE_W
  localparam int unsigned N_W   = 7;
  localparam int unsigned R_W   = 5;

  typedef struct packed {
    logic [N_W-1:0]   n;
    logic [PRE_W-1:0] a;
  } fb_cfg_t;
endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
  parameter int unsigned PRE_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod_hi_i,
  output logic tc_o
);
  localparam logic [PRE_W:0] LAST_LO = (PRE_W+1)'((1 << PRE_W) - 1);
  localparam logic [PRE_W:0] LAST_HI = (PRE_W+1)'(1 << PRE_W);

  logic [PRE_W:0] cnt_q;

  assign tc_o = mod_hi_i ? (cnt_q == LAST_HI) : (cnt_q == LAST_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tc_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_HI); // R3
  AST_PRE_HI_ONLY_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST_HI) |-> mod_hi_i); // R3
endmodule

// File: rtl/pswl_swallow_ctl.sv
module pswl_swallow_ctl
  import pswl_pkg::*;
#(
  parameter logic [N_W-1:0]   N_RST = 7'd75,
  parameter logic [PRE_W-1:0] A_RST = 5'd2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pre_tc_i,
  input  logic    load_i,
  input  fb_cfg_t cfg_i,
  output logic    mod_hi_o,
  output logic    fb_pulse_o
);
  fb_cfg_t        act_q, pend_q;
  logic           pend_v_q;
  logic [N_W-1:0] k_q;
  logic           last_cyc, load_ok;

  assign last_cyc = pre_tc_i && (k_q == (act_q.n - N_W'(1)));
  assign mod_hi_o = k_q < N_W'(act_q.a);
  assign load_ok  = load_i && (cfg_i.n != '0) && (N_W'(cfg_i.a) <= cfg_i.n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '{n: N_RST, a: A_RST};
      pend_q     <= '{n: N_RST, a: A_RST};
      pend_v_q   <= 1'b0;
      k_q        <= '0;
      fb_pulse_o <= 1'b0;
    end else begin
      fb_pulse_o <= last_cyc;
      if (last_cyc)      k_q <= '0;
      else if (pre_tc_i) k_q <= k_q + 1'b1;
      if (last_cyc && pend_v_q) act_q <= pend_q;
      if (load_ok) begin
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end else if (last_cyc) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  AST_FB_CFG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.n != '0) && (N_W'(act_q.a) <= act_q.n)); // R5 R6
  AST_FB_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q < act_q.n); // R2
  AST_FB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o); // R11
  AST_FB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_cyc |=> $stable(act_q)); // R7
endmodule

// File: rtl/pswl_ref_div.sv
module pswl_ref_div #(
  parameter int unsigned    R_W   = 5,
  parameter int unsigned    R_MIN = 5,
  parameter int unsigned    R_MAX = 20,
  parameter logic [R_W-1:0] R_RST = 5'd16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [R_W-1:0] div_i,
  output logic           pulse_o
);
  localparam logic [R_W-1:0] LO = R_W'(R_MIN);
  localparam logic [R_W-1:0] HI = R_W'(R_MAX);

  logic [R_W-1:0] cnt_q, act_q, pend_q;
  logic           pend_v_q, last_cyc, load_ok;

  assign last_cyc = cnt_q == (act_q - R_W'(1));
  assign load_ok  = load_i && (div_i >= LO) && (div_i <= HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      act_q    <= R_RST;
      pend_q   <= R_RST;
      pend_v_q <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      pulse_o <= last_cyc;
      cnt_q   <= last_cyc ? '0 : cnt_q + 1'b1;
      if (last_cyc && pend_v_q) act_q <= pend_q;
      if (load_ok) begin
        pend_q   <= div_i;
        pend_v_q <= 1'b1;
      end else if (last_cyc) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  AST_REF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q >= LO) && (act_q <= HI)); // R9
  AST_REF_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q); // R8
  AST_REF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R11
  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_cyc |=> $stable(act_q)); // R10
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pswl_pkg::*;
#(
  parameter logic [N_W-1:0]   N_RST = 7'd75,
  parameter logic [PRE_W-1:0] A_RST = 5'd2,
  parameter logic [R_W-1:0]   R_RST = 5'd16,
  parameter int unsigned      R_MIN = 5,
  parameter int unsigned      R_MAX = 20
) (
  input  logic             vco_clk_i,
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             fb_load_i,
  input  logic [N_W-1:0]   fb_n_i,
  input  logic [PRE_W-1:0] fb_a_i,
  input  logic             ref_load_i,
  input  logic [R_W-1:0]   ref_div_i,
  output logic             fb_pulse_o,
  output logic             ref_pulse_o
);
  logic    mod_hi, pre_tc;
  fb_cfg_t fb_cfg;

  assign fb_cfg = '{n: fb_n_i, a: fb_a_i};

  pswl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (vco_clk_i),
    .rst_ni   (rst_ni),
    .mod_hi_i (mod_hi),
    .tc_o     (pre_tc)
  );

  pswl_swallow_ctl #(.N_RST(N_RST), .A_RST(A_RST)) u_swl (
    .clk_i      (vco_clk_i),
    .rst_ni     (rst_ni),
    .pre_tc_i   (pre_tc),
    .load_i     (fb_load_i),
    .cfg_i      (fb_cfg),
    .mod_hi_o   (mod_hi),
    .fb_pulse_o (fb_pulse_o)
  );

  pswl_ref_div #(.R_W(R_W), .R_MIN(R_MIN), .R_MAX(R_MAX), .R_RST(R_RST)) u_ref (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ref_load_i),
    .div_i   (ref_div_i),
    .pulse_o (ref_pulse_o)
  );
endmodule

// File: tb/pulse_swallow_div_tb.sv
module pulse_swallow_div_tb;
  logic       vco_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic       fb_load = 1'b0, ref_load = 1'b0;
  logic [6:0] fb_n = '0;
  logic [4:0] fb_a = '0, ref_div = '0;
  logic       fb_pulse, ref_pulse;

  int checks = 0, fails = 0;
  string fb_tag = "R1", ref_tag = "R1";

  always #4  vco_clk = ~vco_clk;   // 125 MHz
  always #13 ref_clk = ~ref_clk;

  pulse_swallow_div u_dut (
    .vco_clk_i(vco_clk), .ref_clk_i(ref_clk), .rst_ni(rst_n),
    .fb_load_i(fb_load), .fb_n_i(fb_n), .fb_a_i(fb_a),
    .ref_load_i(ref_load), .ref_div_i(ref_div),
    .fb_pulse_o(fb_pulse), .ref_pulse_o(ref_pulse)
  );

  // feedback reference model: edge count against 32*N+A
  int  f_cnt, f_n, f_a, f_pn, f_pa;
  bit  f_pv, f_exp;
  always @(posedge vco_clk) begin
    if (!rst_n) begin
      f_cnt = 0; f_n = 75; f_a = 2; f_pv = 0; f_exp = 0;
    end else begin
      f_cnt++;
      f_exp = (f_cnt == 32*f_n + f_a);
      if (f_exp) begin
        f_cnt = 0;
        if (f_pv) begin f_n = f_pn; f_a = f_pa; f_pv = 0; end
      end
      if (fb_load && fb_n != 0 && int'(fb_a) <= int'(fb_n)) begin
        f_pn = int'(fb_n); f_pa = int'(fb_a); f_pv = 1;
      end
    end
  end

  // reference-divider model
  int  r_cnt, r_act, r_pend;
  bit  r_pv, r_exp;
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      r_cnt = 0; r_act = 16; r_pv = 0; r_exp = 0;
    end else begin
      r_cnt++;
      r_exp = (r_cnt == r_act);
      if (r_exp) begin
        r_cnt = 0;
        if (r_pv) begin r_act = r_pend; r_pv = 0; end
      end
      if (ref_load && ref_div >= 5 && ref_div <= 20) begin
        r_pend = int'(ref_div); r_pv = 1;
      end
    end
  end

  always @(negedge vco_clk) if (rst_n) begin
    checks++;
    if (fb_pulse !== f_exp) begin
      fails++;
      $display("FAIL %s fb_pulse_o=%0b expected %0b (t=%0t)", fb_tag, fb_pulse, f_exp, $time);
    end
  end

  always @(negedge ref_clk) if (rst_n) begin
    checks++;
    if (ref_pulse !== r_exp) begin
      fails++;
      $display("FAIL %s ref_pulse_o=%0b expected %0b (t=%0t)", ref_tag, ref_pulse, r_exp, $time);
    end
  end

  task automatic fb_ld(input int n, input int a);
    @(negedge vco_clk);
    fb_n = 7'(n); fb_a = 5'(a); fb_load = 1'b1;
    @(negedge vco_clk);
    fb_load = 1'b0;
  endtask

  task automatic ref_ld(input int r);
    @(negedge ref_clk);
    ref_div = 5'(r); ref_load = 1'b1;
    @(negedge ref_clk);
    ref_load = 1'b0;
  endtask

  task automatic fb_seq();
    fb_tag = "R2"; repeat (5000) @(negedge vco_clk);
    fb_tag = "R7"; fb_ld(3, 1); repeat (2800) @(negedge vco_clk);
    fb_tag = "R3"; fb_ld(2, 0); repeat (400) @(negedge vco_clk);
    fb_tag = "R4"; fb_ld(4, 4); repeat (500) @(negedge vco_clk);
    fb_tag = "R5"; fb_ld(2, 3); repeat (500) @(negedge vco_clk);
    fb_tag = "R6"; fb_ld(0, 0); repeat (500) @(negedge vco_clk);
    fb_tag = "R7"; fb_ld(5, 9); fb_ld(1, 1); fb_ld(6, 31 & 5);
    repeat (800) @(negedge vco_clk);
    fb_tag = "R3"; fb_ld(1, 0); repeat (200) @(negedge vco_clk);
  endtask

  task automatic ref_seq();
    ref_tag = "R8";  repeat (60) @(negedge ref_clk);
    ref_tag = "R10"; ref_ld(5); repeat (60) @(negedge ref_clk);
    ref_tag = "R9";  ref_ld(4); repeat (40) @(negedge ref_clk);
    ref_tag = "R9";  ref_ld(21); repeat (40) @(negedge ref_clk);
    ref_tag = "R8";  ref_ld(20); repeat (80) @(negedge ref_clk);
    ref_tag = "R10"; ref_ld(13); ref_ld(12); repeat (80) @(negedge ref_clk);
    ref_tag = "R11"; repeat (40) @(negedge ref_clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge vco_clk);
    checks++;
    if (fb_pulse !== 1'b0 || ref_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1 pulses=%0b%0b expected 00", fb_pulse, ref_pulse);
    end
    rst_n = 1'b1;
    fork
      fb_seq();
      ref_seq();
    join
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge vco_clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule